// File: doc/BRIEF.md
# Prescaled Watchdog Timer

A watchdog timer attached to a small register bus (byte address, write and read strobes, 16-bit data). Software programs a 16-bit timeout value, picks one of three tick sources and a power-of-four prescaler, clears the counter and sets the enable bit. While enabled, a 16-bit up-counter advances once per prescaled tick. When a tick arrives while the counter equals the timeout value, the counter wraps to zero and the block raises a reset request for one clock cycle. Software keeps the system alive by writing zero to the counter before that happens.

The three tick sources are single-cycle enable strobes that are already synchronous to the block clock: a peripheral-rate strobe, a slow real-time strobe and an external strobe. The prescaler divides the chosen strobe by 1, 4, 16, 64, 256 or 1024. Its phase restarts whenever counting is disabled or the control register is written, so that a freshly programmed period always starts from a whole prescaler period.

A normal programming sequence is: disable, write control, write timeout, zero the counter, write control again with a source selected, enable.

Top module: `prescaled_wdt`

## Requirements
- R1: Registers sit at byte offsets 0x0 (timeout), 0x4 (enable), 0x8 (counter) and 0xC (control), decoded from addr_i[3:2]; an access with addr_i[1:0] nonzero is ignored and reads as zero. A read strobe in cycle N puts the selected register on rdata_o after that clock edge, and rdata_o holds its value until the next read.
- R2: After reset every register reads zero, rdata_o is zero and wdt_rst_o is low.
- R3: Control bits [2:0] select the tick source: bit 0 takes src_tick_i[0], bit 1 takes src_tick_i[1], bit 2 takes src_tick_i[2]. When several bits are set the lowest set bit wins; when none is set the counter never advances.
- R4: Control bits [5:3] hold a prescaler code c; for c of 0 to 5 one tick is produced per 4^c strobes of the selected source, and codes 6 and 7 behave as code 5 (1024).
- R5: While enable is 1 the counter grows by one per tick (wrapping at 16 bits); while enable is 0 it holds its value regardless of strobes.
- R6: A tick that finds the enabled counter equal to the timeout value sets the counter to zero and raises wdt_rst_o for exactly that one following cycle; with a strobe every cycle, prescaler 1 and timeout T, pulses are T+1 cycles apart.
- R7: A write to the counter register loads wdata_i (zero restarts the timeout period) and wins over a tick in the same cycle, which then neither advances the counter nor raises a pulse.
- R8: Writing the control register, or having enable at 0, restarts the prescaler phase, so the first tick after such an event needs a full 4^c fresh strobes.
- R9: Only bit 0 of the enable register is stored and it reads back zero-extended; the control register stores bits [5:0] only and reads back zero-extended; timeout and counter store all 16 bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 4 | Byte address of the register access |
| wr_i | input | 1 | Write strobe |
| rd_i | input | 1 | Read strobe |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data, valid the cycle after rd_i |
| src_tick_i | input | 3 | Tick source strobes: [0] peripheral, [1] real-time, [2] external |
| wdt_rst_o | output | 1 | One-cycle reset request on timeout |

## Verification
The counting path is driven with a continuous strobe on one source, with strobes on unselected or losing sources, with no source selected, and with each prescaler code including the two clamped ones, so that source priority, division ratio and clamping are told apart by the counter value read back. Periodic zero writes against a short timeout separate correct servicing from a missed one, and a nonzero load just below the timeout shows the wrap and the single pulse. Short strobe bursts split by control rewrites or an enable toggle show whether the prescaler phase was restarted. A long stretch of random bus traffic and strobes is compared every cycle against a behavioural model to catch ordering mistakes such as a counter write colliding with a tick.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  typedef enum logic [1:0] {
    REG_TIMEOUT = 2'd0,
    REG_ENABLE  = 2'd1,
    REG_COUNT   = 2'd2,
    REG_CONTROL = 2'd3
  } wdt_reg_e;

  // control register layout: prescaler code above one-hot source select
  typedef struct packed {
    logic [2:0] psc;
    logic [2:0] src;
  } wdt_ctrl_t;
endpackage

// File: rtl/wdt_regs.sv
module wdt_regs
  import wdt_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [DATA_W-1:0] cnt_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic [DATA_W-1:0] timeout_o,
  output logic              en_o,
  output wdt_ctrl_t         ctrl_o,
  output logic              cnt_wr_o,
  output logic              ctrl_wr_o
);
  localparam int CTRL_W = $bits(wdt_ctrl_t);

  logic              aligned;
  wdt_reg_e          sel;
  logic              wr_ok;
  logic [DATA_W-1:0] timeout_q;
  logic              en_q;
  wdt_ctrl_t         ctrl_q;
  logic [DATA_W-1:0] rd_mux;
  logic [DATA_W-1:0] rdata_q;

  assign aligned   = (addr_i[1:0] == 2'b00);
  assign sel       = wdt_reg_e'(addr_i[3:2]);
  assign wr_ok     = wr_i && aligned;
  assign cnt_wr_o  = wr_ok && (sel == REG_COUNT);
  assign ctrl_wr_o = wr_ok && (sel == REG_CONTROL);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      timeout_q <= '0;
      en_q      <= 1'b0;
      ctrl_q    <= '0;
    end else if (wr_ok) begin
      case (sel)
        REG_TIMEOUT: timeout_q <= wdata_i;
        REG_ENABLE:  en_q      <= wdata_i[0];
        REG_CONTROL: ctrl_q    <= wdt_ctrl_t'(wdata_i[CTRL_W-1:0]);
        default:     ;
      endcase
    end
  end

  always_comb begin
    rd_mux = '0;
    if (aligned) begin
      case (sel)
        REG_TIMEOUT: rd_mux = timeout_q;
        REG_ENABLE:  rd_mux = DATA_W'(en_q);
        REG_COUNT:   rd_mux = cnt_i;
        REG_CONTROL: rd_mux = DATA_W'(ctrl_q);
        default:     rd_mux = '0;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_q <= '0;
    else if (rd_i) rdata_q <= rd_mux;
  end

  assign rdata_o   = rdata_q;
  assign timeout_o = timeout_q;
  assign en_o      = en_q;
  assign ctrl_o    = ctrl_q;

  AST_RDATA_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_i |=> $stable(rdata_o)); // R1
  AST_EN_BIT0: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_ok && sel == REG_ENABLE) |=> en_o == $past(wdata_i[0])); // R9
  AST_MISALIGNED_NOWR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !aligned) |=> ($stable(timeout_o) && $stable(en_o) && $stable(ctrl_o))); // R1
endmodule

// File: rtl/wdt_tick_gen.sv
module wdt_tick_gen #(
  parameter int SRC_N    = 3,
  parameter int PSC_W    = 3,
  parameter int MAX_CODE = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [SRC_N-1:0] src_sel_i,
  input  logic [PSC_W-1:0] psc_i,
  input  logic [SRC_N-1:0] src_tick_i,
  input  logic             clr_i,
  output logic             tick_o
);
  localparam int               DIV_W = 2 * MAX_CODE;
  localparam logic [PSC_W-1:0] CODE_CAP = PSC_W'(MAX_CODE);

  logic [SRC_N-1:0] pick;
  logic             strobe;
  logic [PSC_W-1:0] code_eff;
  logic [DIV_W:0]   span;
  logic [DIV_W-1:0] limit;
  logic [DIV_W-1:0] div_q;
  logic             wrap;

  // lowest-numbered selected source wins
  for (genvar i = 0; i < SRC_N; i++) begin : g_pick
    if (i == 0) begin : g_first
      assign pick[i] = src_sel_i[i];
    end else begin : g_rest
      assign pick[i] = src_sel_i[i] && !(|src_sel_i[i-1:0]);
    end
  end

  assign strobe   = |(pick & src_tick_i);
  assign code_eff = (psc_i > CODE_CAP) ? CODE_CAP : psc_i;
  assign span     = (DIV_W+1)'(1) << {code_eff, 1'b0};
  assign limit    = DIV_W'(span - (DIV_W+1)'(1));
  assign wrap     = (div_q == limit);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      div_q <= '0;
    else if (clr_i)   div_q <= '0;
    else if (strobe)  div_q <= wrap ? '0 : div_q + 1'b1;
  end

  assign tick_o = strobe && wrap && !clr_i;

  AST_NO_SRC_NO_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (src_sel_i == '0) |-> !tick_o); // R3
  AST_DIV_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> div_q == '0); // R8
  AST_DIV_IN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    div_q <= limit); // R4
endmodule

// File: rtl/wdt_counter.sv
module wdt_counter #(
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              tick_i,
  input  logic [DATA_W-1:0] timeout_i,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] cnt_o,
  output logic              rst_req_o
);
  logic [DATA_W-1:0] cnt_q;
  logic              step;
  logic              hit;
  logic              rst_q;

  assign step = en_i && tick_i;
  assign hit  = step && (cnt_q == timeout_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      rst_q <= 1'b0;
    end else begin
      rst_q <= hit && !wr_i;
      if (wr_i)      cnt_q <= wdata_i;
      else if (hit)  cnt_q <= '0;
      else if (step) cnt_q <= cnt_q + 1'b1;
    end
  end

  assign cnt_o     = cnt_q;
  assign rst_req_o = rst_q;

  AST_PULSE_AFTER_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_o |-> $past(en_i && tick_i && !wr_i)); // R6
  AST_WRAP_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_o |-> cnt_o == '0); // R6
  AST_SVC_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> (cnt_o == $past(wdata_i) && !rst_req_o)); // R7
  AST_HOLD_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && !wr_i) |=> $stable(cnt_o)); // R5
  AST_STEP_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && tick_i && !wr_i && cnt_o != timeout_i) |=> cnt_o == $past(cnt_o) + 1'b1); // R5
endmodule

// File: rtl/prescaled_wdt.sv
module prescaled_wdt
  import wdt_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int ADDR_W   = 4,
  parameter int SRC_N    = 3,
  parameter int PSC_W    = 3,
  parameter int MAX_CODE = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic [SRC_N-1:0]  src_tick_i,
  output logic              wdt_rst_o
);
  logic [DATA_W-1:0] timeout;
  logic              en;
  wdt_ctrl_t         ctrl;
  logic              cnt_wr;
  logic              ctrl_wr;
  logic [DATA_W-1:0] cnt;
  logic              tick;
  logic              div_clr;

  wdt_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .addr_i    (addr_i),
    .wr_i      (wr_i),
    .rd_i      (rd_i),
    .wdata_i   (wdata_i),
    .cnt_i     (cnt),
    .rdata_o   (rdata_o),
    .timeout_o (timeout),
    .en_o      (en),
    .ctrl_o    (ctrl),
    .cnt_wr_o  (cnt_wr),
    .ctrl_wr_o (ctrl_wr)
  );

  assign div_clr = !en || ctrl_wr;

  wdt_tick_gen #(.SRC_N(SRC_N), .PSC_W(PSC_W), .MAX_CODE(MAX_CODE)) u_tick (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .src_sel_i  (ctrl.src),
    .psc_i      (ctrl.psc),
    .src_tick_i (src_tick_i),
    .clr_i      (div_clr),
    .tick_o     (tick)
  );

  wdt_counter #(.DATA_W(DATA_W)) u_cnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .en_i      (en),
    .tick_i    (tick),
    .timeout_i (timeout),
    .wr_i      (cnt_wr),
    .wdata_i   (wdata_i),
    .cnt_o     (cnt),
    .rst_req_o (wdt_rst_o)
  );

  AST_RST_NEEDS_EN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wdt_rst_o |-> $past(en)); // R5
endmodule

// File: tb/tb_prescaled_wdt.sv
module tb_prescaled_wdt;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [3:0]  addr = '0;
  logic        wr = 1'b0;
  logic        rd = 1'b0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic [2:0]  src_tick = '0;
  logic        wdt_rst;

  int n_chk = 0;
  int n_err = 0;
  int n_pulse = 0;
  int cyc = 0;
  bit done = 0;
  string cur_req = "R2";

  // behavioural model state
  logic [15:0] m_to, m_cnt, m_rdata;
  logic        m_en, m_rst;
  logic [5:0]  m_ctrl;
  int          m_phase, m_code, m_period;
  logic        m_strobe, m_clr, m_tick;

  prescaled_wdt dut (
    .clk_i      (clk),
    .rst_ni     (rst_ni),
    .addr_i     (addr),
    .wr_i       (wr),
    .rd_i       (rd),
    .wdata_i    (wdata),
    .rdata_o    (rdata),
    .src_tick_i (src_tick),
    .wdt_rst_o  (wdt_rst)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      m_to = '0; m_cnt = '0; m_rdata = '0; m_en = 1'b0; m_rst = 1'b0;
      m_ctrl = '0; m_phase = 0;
    end else begin
      m_strobe = 1'b0;
      if (m_ctrl[0])      m_strobe = src_tick[0];
      else if (m_ctrl[1]) m_strobe = src_tick[1];
      else if (m_ctrl[2]) m_strobe = src_tick[2];
      m_code = int'(m_ctrl[5:3]);
      if (m_code > 5) m_code = 5;
      m_period = 1 << (2 * m_code);
      m_clr = !m_en || (wr && addr == 4'hC);
      m_tick = 1'b0;
      if (m_clr) m_phase = 0;
      else if (m_strobe) begin
        m_phase = m_phase + 1;
        if (m_phase == m_period) begin m_phase = 0; m_tick = 1'b1; end
      end
      if (rd) begin
        case (addr)
          4'h0:    m_rdata = m_to;
          4'h4:    m_rdata = {15'd0, m_en};
          4'h8:    m_rdata = m_cnt;
          4'hC:    m_rdata = {10'd0, m_ctrl};
          default: m_rdata = '0;
        endcase
      end
      m_rst = 1'b0;
      if (wr && addr == 4'h8) m_cnt = wdata;
      else if (m_en && m_tick) begin
        if (m_cnt == m_to) begin m_cnt = '0; m_rst = 1'b1; end
        else m_cnt = m_cnt + 16'd1;
      end
      if (wr && addr == 4'h0) m_to = wdata;
      if (wr && addr == 4'h4) m_en = wdata[0];
      if (wr && addr == 4'hC) m_ctrl = wdata[5:0];
    end
  end

  always @(negedge clk) begin
    if (rst_ni && !done) begin
      n_chk++;
      if (wdt_rst !== m_rst || rdata !== m_rdata) begin
        n_err++;
        $display("FAIL %s model: rst=%0b rdata=%h expected rst=%0b rdata=%h",
                 cur_req, wdt_rst, rdata, m_rst, m_rdata);
      end
      if (wdt_rst) n_pulse++;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      done = 1;
      n_err++;
      n_chk++;
      $display("FAIL watchdog expired in %s: cycles=%0d expected below 150000", cur_req, cyc);
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [3:0] a, input logic [15:0] d);
    addr = a; wdata = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic bus_rd(input logic [3:0] a, output logic [15:0] d);
    addr = a; rd = 1'b1;
    @(negedge clk);
    rd = 1'b0;
    d = rdata;
  endtask

  task automatic strobe(input logic [2:0] p, input int n);
    src_tick = p;
    repeat (n) @(negedge clk);
    src_tick = '0;
  endtask

  initial begin
    logic [15:0] v;
    int p0, gap;
    repeat (3) @(negedge clk);
    chk("R2 reset rdata", rdata, 16'h0);
    chk("R2 reset pulse", {15'd0, wdt_rst}, 16'h0);
    rst_ni = 1'b1;
    @(negedge clk);
    bus_rd(4'h0, v); chk("R2 timeout", v, 16'h0);
    bus_rd(4'h4, v); chk("R2 enable", v, 16'h0);
    bus_rd(4'h8, v); chk("R2 counter", v, 16'h0);
    bus_rd(4'hC, v); chk("R2 control", v, 16'h0);

    cur_req = "R1";
    bus_wr(4'h0, 16'h1234); bus_rd(4'h0, v); chk("R1 timeout readback", v, 16'h1234);
    bus_wr(4'h8, 16'hABCD); bus_rd(4'h8, v); chk("R1 counter readback", v, 16'hABCD);
    repeat (3) @(negedge clk);
    chk("R1 rdata holds", rdata, 16'hABCD);
    bus_wr(4'h1, 16'h5555); bus_rd(4'h0, v); chk("R1 misaligned write ignored", v, 16'h1234);
    bus_rd(4'h2, v); chk("R1 misaligned read zero", v, 16'h0);
    cur_req = "R9";
    bus_wr(4'h4, 16'hFFFE); bus_rd(4'h4, v); chk("R9 enable bit0 only", v, 16'h0000);
    bus_wr(4'h4, 16'h0003); bus_rd(4'h4, v); chk("R9 enable reads 1", v, 16'h0001);
    bus_wr(4'h4, 16'h0000);
    bus_wr(4'hC, 16'hFFFF); bus_rd(4'hC, v); chk("R9 control 6 bits", v, 16'h003F);

    cur_req = "R6";
    bus_wr(4'hC, 16'h0000); bus_wr(4'h0, 16'd5); bus_wr(4'h8, 16'h0);
    bus_wr(4'hC, 16'h0001); bus_wr(4'h4, 16'h0001);
    src_tick = 3'b001;
    while (!wdt_rst) @(negedge clk);
    @(negedge clk);
    chk("R6 pulse one cycle", {15'd0, wdt_rst}, 16'h0);
    gap = 1;
    while (!wdt_rst) begin @(negedge clk); gap++; end
    chk("R6 pulse spacing T+1", 16'(gap), 16'd6);
    src_tick = '0;

    cur_req = "R3";
    bus_wr(4'h4, 16'h0); bus_wr(4'h0, 16'd100); bus_wr(4'hC, 16'h0002);
    bus_wr(4'h8, 16'h0); bus_wr(4'h4, 16'h0001);
    strobe(3'b001, 20); bus_rd(4'h8, v); chk("R3 unselected source ignored", v, 16'd0);
    strobe(3'b010, 7);  bus_rd(4'h8, v); chk("R3 selected source counts", v, 16'd7);
    bus_wr(4'hC, 16'h0006);
    strobe(3'b100, 5);  bus_rd(4'h8, v); chk("R3 higher source loses", v, 16'd7);
    strobe(3'b010, 3);  bus_rd(4'h8, v); chk("R3 lowest set source wins", v, 16'd10);
    bus_wr(4'hC, 16'h0000);
    strobe(3'b111, 9);  bus_rd(4'h8, v); chk("R3 no source no count", v, 16'd10);

    cur_req = "R5";
    bus_wr(4'h4, 16'h0); bus_wr(4'hC, 16'h0001);
    strobe(3'b001, 12); bus_rd(4'h8, v); chk("R5 disabled holds", v, 16'd10);
    bus_wr(4'h4, 16'h0001);
    strobe(3'b001, 4);  bus_rd(4'h8, v); chk("R5 enabled advances", v, 16'd14);

    cur_req = "R4";
    bus_wr(4'hC, 16'h0011); bus_wr(4'h8, 16'h0);
    strobe(3'b001, 37); bus_rd(4'h8, v); chk("R4 divide by 16", v, 16'd2);
    bus_wr(4'hC, 16'h0031); bus_wr(4'h8, 16'h0);
    strobe(3'b001, 2055); bus_rd(4'h8, v); chk("R4 code 6 as 1024", v, 16'd2);
    bus_wr(4'hC, 16'h0039); bus_wr(4'h8, 16'h0);
    strobe(3'b001, 1023); bus_rd(4'h8, v); chk("R4 code 7 not yet", v, 16'd0);
    strobe(3'b001, 1);    bus_rd(4'h8, v); chk("R4 code 7 at 1024", v, 16'd1);
    bus_wr(4'h0, 16'd2); bus_wr(4'hC, 16'h0029); bus_wr(4'h8, 16'h0);
    strobe(3'b001, 3200);

    cur_req = "R8";
    bus_wr(4'h0, 16'd100); bus_wr(4'hC, 16'h0009); bus_wr(4'h8, 16'h0);
    strobe(3'b001, 3); bus_wr(4'hC, 16'h0009);
    strobe(3'b001, 3); bus_rd(4'h8, v); chk("R8 control write restarts phase", v, 16'd0);
    strobe(3'b001, 1); bus_rd(4'h8, v); chk("R8 full period after restart", v, 16'd1);
    strobe(3'b001, 3); bus_wr(4'h4, 16'h0); bus_wr(4'h4, 16'h0001);
    strobe(3'b001, 3); bus_rd(4'h8, v); chk("R8 disable restarts phase", v, 16'd1);
    strobe(3'b001, 1); bus_rd(4'h8, v); chk("R8 tick after disable", v, 16'd2);

    cur_req = "R7";
    bus_wr(4'h0, 16'd10); bus_wr(4'hC, 16'h0001); bus_wr(4'h8, 16'h0);
    p0 = n_pulse;
    src_tick = 3'b001;
    for (int i = 0; i < 40; i++) begin
      repeat (4) @(negedge clk);
      bus_wr(4'h8, 16'h0);
    end
    src_tick = '0;
    chk("R7 serviced no pulse", 16'(n_pulse - p0), 16'd0);
    bus_wr(4'h8, 16'd9);
    p0 = n_pulse;
    strobe(3'b001, 2);
    bus_rd(4'h8, v);
    chk("R7 load then timeout pulse", 16'(n_pulse - p0), 16'd1);
    chk("R6 counter wrapped", v, 16'd0);

    cur_req = "R1 R5 R6 R7 R8 random";
    for (int i = 0; i < 6000; i++) begin
      int op;
      src_tick = 3'($urandom);
      op = int'($urandom_range(0, 9));
      addr = {2'($urandom), 2'b00};
      rd = (op == 1 || op == 2);
      wr = (op >= 7);
      case (addr)
        4'h0:    wdata = 16'($urandom_range(0, 12));
        4'hC:    wdata = {10'd0, ($urandom_range(0, 3) == 0) ? 3'($urandom) : 3'd0, 3'($urandom)};
        4'h4:    wdata = 16'($urandom_range(0, 7) != 0);
        default: wdata = 16'($urandom_range(0, 8));
      endcase
      @(negedge clk);
      wr = 1'b0; rd = 1'b0;
    end
    src_tick = '0;
    @(negedge clk);

    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule